// File: doc/BRIEF.md
# I2C Slave Byte Receiver with Clock Stretching

This block is the receive side of a two-wire serial slave. It watches the open-drain clock and data lines, brings both into the system clock domain, and finds start and stop conditions. After a start it gathers the first byte and compares its upper seven bits with a programmed slave address. On a match with the direction bit at 0 (write), it pulls the data line low in the acknowledge slot. Every following byte is gathered most significant bit first and always acknowledged.

At the ninth clock of each accepted byte, including the address byte, the byte is copied into a data register and an interrupt flag is raised. From the falling edge of that ninth clock the block holds the clock line low. It keeps holding it until the host reads the data register. The read, not the clearing of the flag, lets the master go on with the next byte.

The host uses a small register port with a 2-bit select:
- select 0 is control: bit 0 enables the block and bit 1 enables the interrupt.
- select 1 is status: bit 0 is bus busy and bit 1 is the interrupt flag.
- select 2 is the read-only data register.
- select 3 holds the slave address in bits 7:1.

Top module: `i2cSlaveRx`

## Requirements
- R1: While enabled, a start condition (data line falling while the clock line is high) sets the bus-busy bit, status bit 0.
- R2: A stop condition (data line rising while the clock line is high) clears the bus-busy bit.
- R3: When the first byte after a start has bits 7:1 equal to the address register bits 7:1 and bit 0 equal to 0, `sdaDrvLow` is high during the ninth clock.
- R4: When the first byte does not meet R3, the data line stays released on the ninth clock. The block then ignores the bus until the next start or stop: no acknowledge, no interrupt, no stretching, and the data register is left unchanged.
- R5: Bits are taken on rising clock edges, most significant first. After the ninth clock, reading select 2 returns the received byte; after the address byte it returns the address byte itself.
- R6: The interrupt flag, status bit 1, is set at the ninth clock of each accepted byte. `irqOut` is high only while that flag and control bit 1 are both 1.
- R7: `sclDrvLow` goes high at the falling edge of the ninth clock of an accepted byte. It stays high until a read of select 2, and that read releases it.
- R8: A write to select 1 with bit 1 at 0 clears the interrupt flag; a write with bit 1 at 1 leaves it unchanged. Clearing the flag does not release the clock line.
- R9: Every data byte that follows an accepted address is acknowledged, whatever its value.
- R10: A repeated start in the middle of a transfer sends the block back to address comparison.
- R11: While control bit 0 is 0, both line drives stay released, starts are not recognized and bus busy reads 0.
- R12: After reset both drives are released, `irqOut` is 0, and selects 0 to 3 all read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the bus clock rate |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Level of the bus clock line |
| sdaIn | input | 1 | Level of the bus data line |
| sclDrvLow | output | 1 | Pull the clock line low (stretch) |
| sdaDrvLow | output | 1 | Pull the data line low (acknowledge) |
| regSel | input | 2 | Host register select |
| regWr | input | 1 | Host write strobe |
| regRd | input | 1 | Host read strobe |
| regWdata | input | 8 | Host write data |
| regRdata | output | 8 | Host read data for the selected register |
| irqOut | output | 1 | Interrupt request |

## Verification
The checks assume that the host reads the data register only while the block is stretching the clock or idle. They also assume that a single host write never both clears the enable and expects a clean release. The bus model changes the data line only while the clock is low, except to form start and stop conditions. Each bus phase lasts ten system clocks, well beyond the synchronizer delay. After releasing the clock, the bus model always waits until it sees the line high, so it honours stretching. The host model is sequential: it services each byte (status check, flag clear, data read) before the bus model raises the next clock.

// File: rtl/i2cRxPkg.sv
`timescale 1ns/1ps
package i2cRxPkg;

  localparam logic [1:0] SEL_CTRL   = 2'd0;
  localparam logic [1:0] SEL_STATUS = 2'd1;
  localparam logic [1:0] SEL_DATA   = 2'd2;
  localparam logic [1:0] SEL_ADDR   = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_ACK,
    ST_HOLD,
    ST_IGNORE
  } rxStateT;

  typedef struct packed {
    logic shiftEn;
    logic clearCnt;
    logic loadData;
    logic setIrq;
  } rxStrobeT;

endpackage

// File: rtl/i2cRxDatapath.sv
`timescale 1ns/1ps
module i2cRxDatapath
  import i2cRxPkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [1:0]        regSel,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  rxStrobeT          strobe,
  input  logic              busBusy,
  output logic              sclRise,
  output logic              sclFall,
  output logic              startSeen,
  output logic              stopSeen,
  output logic              cntFull,
  output logic              addrMatch,
  output logic              dataRead,
  output logic              ctrlEn,
  output logic              irqEn,
  output logic              irqFlag
);

  localparam int ADDR_W = DATA_W - 1;
  localparam int CNT_W  = $clog2(DATA_W + 1);

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic                   sclS, sdaS, sclPrev, sdaPrev;
  logic [DATA_W-1:0]      shiftReg, dataReg;
  logic [CNT_W-1:0]       bitCnt;
  logic [ADDR_W-1:0]      addrReg;

  // two-flop style synchronizers followed by an edge-detect stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclS      = sclSync[SYNC_STAGES-1];
  assign sdaS      = sdaSync[SYNC_STAGES-1];
  assign sclRise   = sclS & ~sclPrev;
  assign sclFall   = ~sclS & sclPrev;
  assign startSeen = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopSeen  = sclS & sclPrev & ~sdaPrev & sdaS;

  // bit gathering
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
    end else if (strobe.clearCnt) begin
      bitCnt <= '0;
    end else if (strobe.shiftEn) begin
      shiftReg <= {shiftReg[DATA_W-2:0], sdaS};
      bitCnt   <= bitCnt + 1'b1;
    end
  end

  assign cntFull   = (bitCnt == CNT_W'(DATA_W));
  assign addrMatch = (shiftReg[DATA_W-1:1] == addrReg) & ~shiftReg[0];

  // host registers
  assign dataRead = regRd & (regSel == SEL_DATA);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlEn  <= 1'b0;
      irqEn   <= 1'b0;
      addrReg <= '0;
      irqFlag <= 1'b0;
      dataReg <= '0;
    end else begin
      if (regWr && regSel == SEL_CTRL) begin
        ctrlEn <= regWdata[0];
        irqEn  <= regWdata[1];
      end
      if (regWr && regSel == SEL_ADDR) addrReg <= regWdata[DATA_W-1:1];
      if (strobe.setIrq)
        irqFlag <= 1'b1;
      else if (regWr && regSel == SEL_STATUS && !regWdata[1])
        irqFlag <= 1'b0;
      if (strobe.loadData) dataReg <= shiftReg;
    end
  end

  always_comb begin
    regRdata = '0;
    unique case (regSel)
      SEL_CTRL:   begin regRdata[0] = ctrlEn;  regRdata[1] = irqEn;   end
      SEL_STATUS: begin regRdata[0] = busBusy; regRdata[1] = irqFlag; end
      SEL_DATA:   regRdata = dataReg;
      SEL_ADDR:   regRdata = {addrReg, 1'b0};
      default:    regRdata = '0;
    endcase
  end

endmodule

// File: rtl/i2cRxControl.sv
`timescale 1ns/1ps
module i2cRxControl
  import i2cRxPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     ctrlEn,
  input  logic     sclRise,
  input  logic     sclFall,
  input  logic     startSeen,
  input  logic     stopSeen,
  input  logic     cntFull,
  input  logic     addrMatch,
  input  logic     dataRead,
  output rxStrobeT strobe,
  output logic     busBusy,
  output logic     sclDrvLow,
  output logic     sdaDrvLow
);

  rxStateT state, nxtState;

  always_comb begin
    nxtState = state;
    strobe   = '0;
    if (!ctrlEn) begin
      nxtState = ST_IDLE;
    end else if (startSeen) begin
      nxtState        = ST_ADDR;
      strobe.clearCnt = 1'b1;
    end else if (stopSeen) begin
      nxtState = ST_IDLE;
    end else begin
      unique case (state)
        ST_ADDR: begin
          if (sclRise)                strobe.shiftEn = 1'b1;
          else if (sclFall && cntFull) nxtState = addrMatch ? ST_ACK : ST_IGNORE;
        end
        ST_DATA: begin
          if (sclRise)                strobe.shiftEn = 1'b1;
          else if (sclFall && cntFull) nxtState = ST_ACK;
        end
        ST_ACK: begin
          if (sclRise) begin
            strobe.setIrq   = 1'b1;
            strobe.loadData = 1'b1;
          end else if (sclFall) begin
            nxtState = ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (dataRead) begin
            nxtState        = ST_DATA;
            strobe.clearCnt = 1'b1;
          end
        end
        default: nxtState = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      busBusy <= 1'b0;
    end else begin
      state <= nxtState;
      if (!ctrlEn)        busBusy <= 1'b0;
      else if (startSeen) busBusy <= 1'b1;
      else if (stopSeen)  busBusy <= 1'b0;
    end
  end

  assign sclDrvLow = (state == ST_HOLD);
  assign sdaDrvLow = (state == ST_ACK);

endmodule

// File: rtl/i2cSlaveRx.sv
`timescale 1ns/1ps
module i2cSlaveRx
  import i2cRxPkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sclDrvLow,
  output logic              sdaDrvLow,
  input  logic [1:0]        regSel,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              irqOut
);

  rxStrobeT strobe;
  logic busBusy, sclRise, sclFall, startSeen, stopSeen, cntFull, addrMatch;
  logic dataRead, ctrlEn, irqEn, irqFlag;

  i2cRxDatapath #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_datapath (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .regSel(regSel), .regWr(regWr), .regRd(regRd), .regWdata(regWdata),
    .regRdata(regRdata), .strobe(strobe), .busBusy(busBusy),
    .sclRise(sclRise), .sclFall(sclFall), .startSeen(startSeen),
    .stopSeen(stopSeen), .cntFull(cntFull), .addrMatch(addrMatch),
    .dataRead(dataRead), .ctrlEn(ctrlEn), .irqEn(irqEn), .irqFlag(irqFlag)
  );

  i2cRxControl u_control (
    .clk(clk), .rstN(rstN), .ctrlEn(ctrlEn), .sclRise(sclRise),
    .sclFall(sclFall), .startSeen(startSeen), .stopSeen(stopSeen),
    .cntFull(cntFull), .addrMatch(addrMatch), .dataRead(dataRead),
    .strobe(strobe), .busBusy(busBusy), .sclDrvLow(sclDrvLow),
    .sdaDrvLow(sdaDrvLow)
  );

  assign irqOut = irqFlag & irqEn;

endmodule

// File: rtl/i2cSlaveRxChecker.sv
`timescale 1ns/1ps
module i2cSlaveRxChecker (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] regSel,
  input logic       regWr,
  input logic       regRd,
  input logic       sclDrvLow,
  input logic       sdaDrvLow,
  input logic       ctrlEn,
  input logic       irqFlag
);

  logic hostDataRead, hostStatusWr;
  assign hostDataRead = regRd & (regSel == 2'd2);
  assign hostStatusWr = regWr & (regSel == 2'd1);

  assert_off_released_R11: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlEn |-> (!sclDrvLow && !sdaDrvLow));

  assert_release_by_read_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(sclDrvLow) && ctrlEn) |-> $past(hostDataRead));

  assert_stretch_holds_R7: assert property (@(posedge clk) disable iff (!rstN)
    (sclDrvLow && ctrlEn && !hostDataRead) |=> sclDrvLow);

  assert_ack_not_in_stretch_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(sclDrvLow && sdaDrvLow));

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (irqFlag && !hostStatusWr) |=> irqFlag);

endmodule

bind i2cSlaveRx i2cSlaveRxChecker u_checker (
  .clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr), .regRd(regRd),
  .sclDrvLow(sclDrvLow), .sdaDrvLow(sdaDrvLow), .ctrlEn(ctrlEn),
  .irqFlag(irqFlag)
);

// File: tb/test_i2cSlaveRx.sv
`timescale 1ns/1ps
module test_i2cSlaveRx;

  localparam int H = 10;
  localparam logic [1:0] S_CTRL = 2'd0, S_STAT = 2'd1, S_DATA = 2'd2, S_ADDR = 2'd3;

  logic clk = 1'b0, rstN = 1'b0;
  logic mScl = 1'b1, mSda = 1'b1;
  logic sclDrvLow, sdaDrvLow, irqOut;
  logic [1:0] regSel = '0;
  logic regWr = 1'b0, regRd = 1'b0;
  logic [7:0] regWdata = '0, regRdata;
  logic sclLine, sdaLine;

  int tests = 0, failed = 0;
  logic [6:0] myAddr = 7'h2D;
  logic [7:0] lastData = 8'h00;
  logic irqMid;

  always #2 clk = ~clk;

  assign sclLine = mScl & ~sclDrvLow;
  assign sdaLine = mSda & ~sdaDrvLow;

  i2cSlaveRx i_i2cSlaveRx (
    .clk(clk), .rstN(rstN), .sclIn(sclLine), .sdaIn(sdaLine),
    .sclDrvLow(sclDrvLow), .sdaDrvLow(sdaDrvLow), .regSel(regSel),
    .regWr(regWr), .regRd(regRd), .regWdata(regWdata), .regRdata(regRdata),
    .irqOut(irqOut)
  );

  function automatic bit addrHit(input logic [7:0] b, input logic [6:0] a);
    return (b[7:1] == a) && !b[0];
  endfunction

  task automatic checkEq(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hostWrite(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    regSel = sel; regWdata = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic hostRead(input logic [1:0] sel, output logic [7:0] d);
    @(negedge clk);
    regSel = sel; regRd = 1'b1;
    #1 d = regRdata;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic waitSclHigh();
    while (!sclLine) @(negedge clk);
  endtask

  task automatic masterStart();
    mSda = 1'b1; waitClk(H);
    mScl = 1'b1; waitSclHigh(); waitClk(H);
    mSda = 1'b0; waitClk(H);
    mScl = 1'b0; waitClk(H);
  endtask

  task automatic masterStop();
    mScl = 1'b0; mSda = 1'b0; waitClk(H);
    mScl = 1'b1; waitSclHigh(); waitClk(H);
    mSda = 1'b1; waitClk(H);
  endtask

  task automatic masterBit(input logic b);
    mSda = b; waitClk(H);
    mScl = 1'b1; waitSclHigh(); waitClk(H);
    mScl = 1'b0; waitClk(H);
  endtask

  task automatic masterByte(input logic [7:0] v, output logic acked);
    for (int i = 7; i >= 0; i--) masterBit(v[i]);
    mSda = 1'b1; waitClk(H);
    mScl = 1'b1; waitSclHigh(); waitClk(H);
    acked  = ~sdaLine;
    irqMid = irqOut;
    mScl = 1'b0; waitClk(H);
  endtask

  // host service of an accepted byte
  task automatic serviceByte(input logic [7:0] expByte, input logic ien);
    logic [7:0] r;
    checkEq("R6 irqOut at ninth clock", irqMid, ien);
    checkEq("R7 stretch after ninth clock", sclDrvLow, 1'b1);
    hostRead(S_STAT, r);
    checkEq("R6 flag set", r[1], 1'b1);
    hostWrite(S_STAT, 8'h02);
    hostRead(S_STAT, r);
    checkEq("R8 write with bit1=1 keeps flag", r[1], 1'b1);
    hostWrite(S_STAT, 8'h00);
    hostRead(S_STAT, r);
    checkEq("R8 flag cleared", r[1], 1'b0);
    checkEq("R8 clear keeps stretch", sclDrvLow, 1'b1);
    hostRead(S_DATA, r);
    checkEq("R5 data register", r, expByte);
    lastData = expByte;
    waitClk(2);
    checkEq("R7 read releases clock", sclDrvLow, 1'b0);
  endtask

  task automatic doTxn(input logic [7:0] addrByte, input int nData,
                       input logic [7:0] d0, input logic [7:0] d1,
                       input logic [7:0] d2, input logic [7:0] d3, input logic ien);
    logic ack, hit;
    logic [7:0] r;
    logic [7:0] dv [4];
    dv[0] = d0; dv[1] = d1; dv[2] = d2; dv[3] = d3;
    hostWrite(S_CTRL, {6'b0, ien, 1'b1});
    masterStart();
    hostRead(S_STAT, r);
    checkEq("R1 busy after start", r[0], 1'b1);
    hit = addrHit(addrByte, myAddr);
    masterByte(addrByte, ack);
    if (hit) begin
      checkEq("R3 address ack", ack, 1'b1);
      serviceByte(addrByte, ien);
    end else begin
      checkEq("R4 address nack", ack, 1'b0);
      checkEq("R4 no irq", irqMid, 1'b0);
      checkEq("R4 no stretch", sclDrvLow, 1'b0);
    end
    for (int k = 0; k < nData; k++) begin
      masterByte(dv[k], ack);
      if (hit) begin
        checkEq("R9 data ack", ack, 1'b1);
        serviceByte(dv[k], ien);
      end else begin
        checkEq("R4 ignored byte nack", ack, 1'b0);
        checkEq("R4 ignored byte stretch", sclDrvLow, 1'b0);
        hostRead(S_STAT, r);
        checkEq("R4 ignored byte flag", r[1], 1'b0);
        hostRead(S_DATA, r);
        checkEq("R4 data register unchanged", r, lastData);
      end
    end
    masterStop();
    hostRead(S_STAT, r);
    checkEq("R2 busy cleared by stop", r[0], 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

  initial begin
    logic [7:0] r;
    logic ack;
    int seedDummy;
    seedDummy = $urandom(32'd2024);
    waitClk(3);
    checkEq("R12 sda released in reset", sdaDrvLow, 1'b0);
    rstN = 1'b1;
    waitClk(2);
    checkEq("R12 scl released", sclDrvLow, 1'b0);
    checkEq("R12 sda released", sdaDrvLow, 1'b0);
    checkEq("R12 irqOut low", irqOut, 1'b0);
    for (int s = 0; s < 4; s++) begin
      hostRead(2'(s), r);
      checkEq("R12 register reads zero", r, 8'h00);
    end

    hostWrite(S_ADDR, {myAddr, 1'b0});
    hostRead(S_ADDR, r);
    checkEq("R3 address register readback", r, {myAddr, 1'b0});

    // directed: match with extreme data values
    doTxn({myAddr, 1'b0}, 3, 8'h00, 8'hFF, 8'hA5, 8'h00, 1'b1);
    // directed: read direction bit is not accepted
    doTxn({myAddr, 1'b1}, 2, 8'h12, 8'h34, 8'h00, 8'h00, 1'b1);
    // directed: wrong address, bytes ignored
    doTxn({myAddr ^ 7'h01, 1'b0}, 2, 8'h55, 8'hAA, 8'h00, 8'h00, 1'b0);

    // R10 repeated start
    hostWrite(S_CTRL, 8'h03);
    masterStart();
    masterByte({myAddr, 1'b0}, ack);
    checkEq("R10 first address ack", ack, 1'b1);
    serviceByte({myAddr, 1'b0}, 1'b1);
    masterByte(8'h3C, ack);
    serviceByte(8'h3C, 1'b1);
    masterStart();
    hostRead(S_STAT, r);
    checkEq("R10 busy across repeated start", r[0], 1'b1);
    masterByte({~myAddr, 1'b0}, ack);
    checkEq("R10 wrong address after repeated start", ack, 1'b0);
    masterStart();
    masterByte({myAddr, 1'b0}, ack);
    checkEq("R10 address compared again", ack, 1'b1);
    serviceByte({myAddr, 1'b0}, 1'b1);
    masterByte(8'hC3, ack);
    checkEq("R10 data after repeated start", ack, 1'b1);
    serviceByte(8'hC3, 1'b1);
    masterStop();

    // R11 disabled block
    hostWrite(S_CTRL, 8'h02);
    masterStart();
    hostRead(S_STAT, r);
    checkEq("R11 busy stays low when disabled", r[0], 1'b0);
    masterByte({myAddr, 1'b0}, ack);
    checkEq("R11 no ack when disabled", ack, 1'b0);
    checkEq("R11 no stretch when disabled", sclDrvLow, 1'b0);
    masterStop();

    // random transactions
    for (int t = 0; t < 12; t++) begin
      logic [7:0] a;
      a = ($urandom % 2 == 0) ? {myAddr, 1'b0} : 8'($urandom);
      doTxn(a, 1 + ($urandom % 4), 8'($urandom), 8'($urandom),
            8'($urandom), 8'($urandom), 1'($urandom));
    end

    $display("  [TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

endmodule